// File: doc/BRIEF.md
# TAP User Register Extension

This block sits next to an IEEE 1149.1 test access port and gives core logic two scan instructions of its own. It reads the TAP controller state and the current instruction. From these it produces two select strobes, one for each user instruction. It also produces a gated data-register clock for user test registers built in the core, and an idle signal for those registers.

On the serial path, the block holds the single-stage bypass register. It picks the bit to shift out from four places: the bypass register, an internal data register, one of the two user serial returns, or the instruction register. The chosen bit is registered onto TDO on the falling edge of TCK.

The TAP state machine and the user registers are outside the block. The state is supplied on a 4-bit bus that uses the conventional 16-state encoding.

Top module: `tap_user_ext`

## Requirements
- R1: `sel1_o` is high exactly when `ir_i` equals `USER1_OP` (default 4'h2).
- R2: `sel2_o` is high exactly when `ir_i` equals `USER2_OP` (default 4'h3). The two selects are never high together.
- R3: `idle_o` is the NAND of `tck_i` and (`tap_state_i` == Run-Test/Idle, code 4'hC). It is low only while TCK is high in that state.
- R4: `drck_o` follows `tck_i` only while a user instruction is loaded and the state is capture-DR (4'h6) or shift-DR (4'h2). Otherwise it stays low. Its enable is taken on the falling edge of TCK, so each pulse is a whole high phase.
- R5: When the bypass register is the selected data register, its flop loads 0 on a rising TCK edge in capture-DR and loads `tdi_i` on a rising edge in shift-DR. It then appears on TDO one shift later.
- R6: In shift-DR, TDO carries the source chosen by instruction. USER1_OP selects `user_tdo1_i` and USER2_OP selects `user_tdo2_i`. EXTEST (4'h0) and SAMPLE (4'h1) select `dr_tdo_i`. Every other opcode, including all-ones (4'hF) and unused codes, selects the bypass register.
- R7: In shift-IR (4'hA), TDO carries `ir_tdo_i`.
- R8: `tdo_o` and `tdo_en_o` change only on the falling edge of TCK. `tdo_en_o` is high after a falling edge taken in shift-DR or shift-IR, and low after any other.
- R9: While `rst_ni` is low, `tdo_o`, `tdo_en_o`, `drck_o` and the bypass flop are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tap_state_i | input | 4 | TAP controller state code |
| ir_i | input | IR_W | Current (updated) instruction |
| tdi_i | input | 1 | Serial test data in |
| ir_tdo_i | input | 1 | Serial output of the instruction register |
| dr_tdo_i | input | 1 | Serial output of the internal boundary data register |
| user_tdo1_i | input | 1 | Serial return of user register 1 |
| user_tdo2_i | input | 1 | Serial return of user register 2 |
| sel1_o | output | 1 | User instruction 1 decoded |
| sel2_o | output | 1 | User instruction 2 decoded |
| drck_o | output | 1 | Gated data-register clock for user logic |
| idle_o | output | 1 | NAND of TCK and Run-Test/Idle |
| tdo_o | output | 1 | Registered serial test data out |
| tdo_en_o | output | 1 | TDO output enable |

## Verification
The hardest case to reach is the data-register clock. Its enable is sampled on one edge and used in the next high phase, so a state or instruction change shows up only half a cycle later. The stimulus holds each pair of state and instruction across a full TCK period. It sweeps every state code against the user and non-user opcodes. The high phase checks the pulse, and the low phase checks that the clock is quiet. The bypass path is driven through capture-DR and a shift stream, and the stream comes back one bit late with the captured 0 first.

// File: rtl/tap_ext_pkg.sv
`timescale 1ns/1ps
package tap_ext_pkg;
  localparam int NUM_USER = 2;

  typedef enum logic [3:0] {
    ST_EXIT2_DR = 4'h0, ST_EXIT1_DR = 4'h1, ST_SHIFT_DR = 4'h2, ST_PAUSE_DR = 4'h3,
    ST_SEL_IR   = 4'h4, ST_UPD_DR   = 4'h5, ST_CAP_DR   = 4'h6, ST_SEL_DR   = 4'h7,
    ST_EXIT2_IR = 4'h8, ST_EXIT1_IR = 4'h9, ST_SHIFT_IR = 4'hA, ST_PAUSE_IR = 4'hB,
    ST_RTI      = 4'hC, ST_UPD_IR   = 4'hD, ST_CAP_IR   = 4'hE, ST_TLR      = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    SRC_BYPASS = 2'd0,
    SRC_DR     = 2'd1,
    SRC_USER1  = 2'd2,
    SRC_USER2  = 2'd3
  } dr_src_e;
endpackage

// File: rtl/tap_ext_decode.sv
`timescale 1ns/1ps
module tap_ext_decode
  import tap_ext_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] USER1_OP  = 4'h2,
  parameter logic [IR_W-1:0] USER2_OP  = 4'h3,
  parameter logic [IR_W-1:0] EXTEST_OP = 4'h0,
  parameter logic [IR_W-1:0] SAMPLE_OP = 4'h1
) (
  input  logic [IR_W-1:0]     ir_i,
  output logic [NUM_USER-1:0] user_sel_o,
  output dr_src_e             dr_src_o
);
  localparam logic [IR_W-1:0] USER_OP [NUM_USER] = '{USER1_OP, USER2_OP};

  for (genvar g = 0; g < NUM_USER; g++) begin : g_user
    assign user_sel_o[g] = (ir_i == USER_OP[g]);
  end

  // user opcodes win over the boundary ones; anything unknown falls to bypass
  always_comb begin
    if (user_sel_o[0])                              dr_src_o = SRC_USER1;
    else if (user_sel_o[1])                         dr_src_o = SRC_USER2;
    else if (ir_i == EXTEST_OP || ir_i == SAMPLE_OP) dr_src_o = SRC_DR;
    else                                            dr_src_o = SRC_BYPASS;
  end
endmodule

// File: rtl/tap_ext_bypass.sv
`timescale 1ns/1ps
module tap_ext_bypass (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic tdi_i,
  output logic q_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= 1'b0;
    else if (sel_i && capture_i) q_o <= 1'b0;
    else if (sel_i && shift_i)   q_o <= tdi_i;
  end
endmodule

// File: rtl/tap_ext_clk_gate.sv
`timescale 1ns/1ps
module tap_ext_clk_gate (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic en_q;

  // enable moves only while TCK is low, so the AND cannot glitch
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign gclk_o = tck_i & en_q;
endmodule

// File: rtl/tap_ext_tdo.sv
`timescale 1ns/1ps
module tap_ext_tdo
  import tap_ext_pkg::*;
(
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                shift_dr_i,
  input  logic                shift_ir_i,
  input  dr_src_e             dr_src_i,
  input  logic                bypass_i,
  input  logic                dr_tdo_i,
  input  logic [NUM_USER-1:0] user_tdo_i,
  input  logic                ir_tdo_i,
  output logic                tdo_o,
  output logic                tdo_en_o
);
  logic dr_bit;

  always_comb begin
    unique case (dr_src_i)
      SRC_USER1: dr_bit = user_tdo_i[0];
      SRC_USER2: dr_bit = user_tdo_i[1];
      SRC_DR:    dr_bit = dr_tdo_i;
      default:   dr_bit = bypass_i;
    endcase
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else begin
      tdo_en_o <= shift_dr_i | shift_ir_i;
      if (shift_ir_i)      tdo_o <= ir_tdo_i;
      else if (shift_dr_i) tdo_o <= dr_bit;
    end
  end
endmodule

// File: rtl/tap_user_ext.sv
`timescale 1ns/1ps
module tap_user_ext
  import tap_ext_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] USER1_OP  = 4'h2,
  parameter logic [IR_W-1:0] USER2_OP  = 4'h3,
  parameter logic [IR_W-1:0] EXTEST_OP = 4'h0,
  parameter logic [IR_W-1:0] SAMPLE_OP = 4'h1
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic [3:0]      tap_state_i,
  input  logic [IR_W-1:0] ir_i,
  input  logic            tdi_i,
  input  logic            ir_tdo_i,
  input  logic            dr_tdo_i,
  input  logic            user_tdo1_i,
  input  logic            user_tdo2_i,
  output logic            sel1_o,
  output logic            sel2_o,
  output logic            drck_o,
  output logic            idle_o,
  output logic            tdo_o,
  output logic            tdo_en_o
);
  logic [NUM_USER-1:0] user_sel;
  dr_src_e             dr_src;
  logic                st_cap_dr, st_shift_dr, st_shift_ir, st_rti;
  logic                bypass_q;

  assign st_cap_dr   = (tap_state_i == ST_CAP_DR);
  assign st_shift_dr = (tap_state_i == ST_SHIFT_DR);
  assign st_shift_ir = (tap_state_i == ST_SHIFT_IR);
  assign st_rti      = (tap_state_i == ST_RTI);

  tap_ext_decode #(
    .IR_W(IR_W), .USER1_OP(USER1_OP), .USER2_OP(USER2_OP),
    .EXTEST_OP(EXTEST_OP), .SAMPLE_OP(SAMPLE_OP)
  ) u_decode (
    .ir_i       (ir_i),
    .user_sel_o (user_sel),
    .dr_src_o   (dr_src)
  );

  tap_ext_bypass u_bypass (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .sel_i     (dr_src == SRC_BYPASS),
    .capture_i (st_cap_dr),
    .shift_i   (st_shift_dr),
    .tdi_i     (tdi_i),
    .q_o       (bypass_q)
  );

  tap_ext_clk_gate u_drck (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .en_i   ((|user_sel) && (st_cap_dr || st_shift_dr)),
    .gclk_o (drck_o)
  );

  tap_ext_tdo u_tdo (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .shift_dr_i (st_shift_dr),
    .shift_ir_i (st_shift_ir),
    .dr_src_i   (dr_src),
    .bypass_i   (bypass_q),
    .dr_tdo_i   (dr_tdo_i),
    .user_tdo_i ({user_tdo2_i, user_tdo1_i}),
    .ir_tdo_i   (ir_tdo_i),
    .tdo_o      (tdo_o),
    .tdo_en_o   (tdo_en_o)
  );

  assign sel1_o = user_sel[0];
  assign sel2_o = user_sel[1];
  assign idle_o = ~(tck_i & st_rti);
endmodule

// File: rtl/tap_user_ext_chk.sv
`timescale 1ns/1ps
module tap_user_ext_chk
  import tap_ext_pkg::*;
(
  input logic       tck_i,
  input logic       rst_ni,
  input logic [3:0] tap_state_i,
  input logic       sel1_o,
  input logic       sel2_o,
  input logic       drck_o,
  input logic       idle_o,
  input logic       tdo_en_o
);
  logic ran_q;
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) ran_q <= 1'b0;
    else         ran_q <= 1'b1;
  end

  p_sel_excl_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({sel1_o, sel2_o}));

  p_drck_low_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !drck_o);

  p_idle_tck_low_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    idle_o);

  p_idle_rti_r3: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (tap_state_i == ST_RTI) |-> !idle_o);

  p_tdo_en_r8: assert property (@(negedge tck_i) disable iff (!rst_ni)
    ran_q |-> (tdo_en_o == $past(tap_state_i == ST_SHIFT_DR || tap_state_i == ST_SHIFT_IR)));
endmodule

bind tap_user_ext tap_user_ext_chk u_chk (
  .tck_i       (tck_i),
  .rst_ni      (rst_ni),
  .tap_state_i (tap_state_i),
  .sel1_o      (sel1_o),
  .sel2_o      (sel2_o),
  .drck_o      (drck_o),
  .idle_o      (idle_o),
  .tdo_en_o    (tdo_en_o)
);

// File: tb/tap_user_ext_tb.sv
`timescale 1ns/1ps
module tap_user_ext_tb;
  logic       tck = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] state = 4'hF;
  logic [3:0] ir = 4'hF;
  logic       tdi = 1'b0, ir_tdo = 1'b0, dr_tdo = 1'b0, u1 = 1'b0, u2 = 1'b0;
  logic       sel1, sel2, drck, idle, tdo, tdo_en;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 tck = ~tck;

  tap_user_ext u_dut (
    .tck_i(tck), .rst_ni(rst_ni), .tap_state_i(state), .ir_i(ir), .tdi_i(tdi),
    .ir_tdo_i(ir_tdo), .dr_tdo_i(dr_tdo), .user_tdo1_i(u1), .user_tdo2_i(u2),
    .sel1_o(sel1), .sel2_o(sel2), .drck_o(drck), .idle_o(idle),
    .tdo_o(tdo), .tdo_en_o(tdo_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic is_user(input logic [3:0] op);
    return op == 4'h2 || op == 4'h3;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [6];
    logic [3:0] sts [4];
    logic [15:0] stream;
    ops = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hF, 4'h7};
    sts = '{4'h2, 4'hA, 4'hC, 4'h3};

    // R9: reset values, with shift state and a user op present
    state = 4'h2; ir = 4'h2;
    #9;
    chk("R9 tdo", tdo, 1'b0);
    chk("R9 tdo_en", tdo_en, 1'b0);
    chk("R9 drck", drck, 1'b0);
    state = 4'hF; ir = 4'hF;
    @(posedge tck); #0.5 rst_ni = 1'b1;

    // R1/R2: decode sweep
    for (int i = 0; i < 16; i++) begin
      ir = 4'(i); #0.1;
      chk("R1 sel1", sel1, i == 2);
      chk("R2 sel2", sel2, i == 3);
    end

    // R3/R4: all states x user and non-user ops, held a full period
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 6; k++) begin
        @(posedge tck); #0.5 state = 4'(s); ir = ops[k];
        @(posedge tck); #1;
        chk("R4 drck high phase", drck, is_user(ops[k]) && (s == 6 || s == 2));
        chk("R3 idle high phase", idle, !(s == 12));
        #2;
        chk("R4 drck low phase", drck, 1'b0);
        chk("R3 idle low phase", idle, 1'b1);
      end
    end

    // R6/R7/R8: TDO routing under every input pattern
    tdi = 1'b0;
    for (int k = 0; k < 6; k++) begin
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 16; p++) begin
          logic ex;
          @(posedge tck); #0.5;
          ir = ops[k]; state = sts[s];
          dr_tdo = p[0]; u1 = p[1]; u2 = p[2]; ir_tdo = p[3];
          @(negedge tck); #1;
          chk("R8 tdo_en", tdo_en, sts[s] == 4'h2 || sts[s] == 4'hA);
          if (sts[s] == 4'hA) chk("R7 tdo from ir", tdo, p[3]);
          else if (sts[s] == 4'h2) begin
            case (ops[k])
              4'h2:       ex = p[1];
              4'h3:       ex = p[2];
              4'h0, 4'h1: ex = p[0];
              default:    ex = 1'b0; // bypass holds 0 while tdi is 0
            endcase
            chk("R6 tdo in shift-DR", tdo, ex);
          end
        end
      end
    end

    // R5: bypass capture then shift, for the all-ones op and an unused op
    stream = 16'b1011_0010_1110_0101;
    for (int k = 4; k < 6; k++) begin
      @(posedge tck); #0.5; ir = ops[k]; state = 4'h6; tdi = 1'b1;
      for (int i = 0; i < 16; i++) begin
        @(posedge tck); #0.5; state = 4'h2; tdi = stream[i];
        @(negedge tck); #1;
        chk("R5 bypass delay", tdo, (i == 0) ? 1'b0 : stream[i-1]);
      end
      @(posedge tck); #0.5; state = 4'h1;
    end

    // R8: output frozen while TCK is high
    @(posedge tck); #0.5; state = 4'hA; ir_tdo = 1'b1;
    @(negedge tck); #1;
    @(posedge tck); #0.1; ir_tdo = 1'b0; state = 4'h3; #1.5;
    chk("R8 tdo before fall", tdo, 1'b1);
    chk("R8 en before fall", tdo_en, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule